// File: doc/BRIEF.md
# Timer-Triggered Parallel Pattern Output

This block drives a 16-bit parallel output word that changes only on timer events. Software loads a starting value into the live output register and stages the following value in a separate next-data buffer. When a chosen compare timer reaches its period, every enabled bit of a group copies its bit from the buffer into the live register. That timer's match flag then asks an external refill engine for the next buffer word and, if wanted, a new period.

The word has two 8-bit groups, and each group names its own trigger timer. Each compare timer counts from zero while its run input is high. When the count equals the period register, the counter returns to zero and the timer's match flag is set. Writing a new period after each step changes the interval to the next step. The flag stays set until a refill-done strobe or a software write-zero strobe clears it.

Each timer has two enumerated state machines. The count machine has the states `CNT_HALT` and `CNT_RUN`. It goes to `CNT_RUN` while `tmr_run` is high and back to `CNT_HALT` when it drops. The flag machine has the states `FLG_IDLE` and `FLG_PEND`. It goes from idle to pending on a compare match. It returns to idle on a clear strobe in a cycle with no new match.

Top module: `pulse_pattern_out`

## Requirements
- R1: After reset the live register, the next-data buffer, all counters, all periods and all match flags are zero, so `pin_out` and `match_flag` read zero.
- R2: A counter advances by one per clock only while its count machine is in `CNT_RUN`. That state is entered one clock after `tmr_run` rises. In `CNT_HALT` the count is held.
- R3: A compare match occurs when a running counter equals its period register, and the counter then returns to zero. With period P the matches are P+1 clocks apart. After reset, a match is flagged on the fifth clock edge after `tmr_run` rises with P=3.
- R4: A period written in a given cycle is used from the next compare onward. A match in the cycle of the write still uses the old period.
- R5: A match sets that timer's flag on the following edge, and the flag stays set until it is cleared.
- R6: `refill_done` or `flag_wr0` for a timer clears its flag. If a match happens in the same cycle, the flag stays set.
- R7: When a group's trigger fires, each bit of that group whose `nde_mask` bit is 1 takes the buffer value. Bits whose `nde_mask` bit is 0 keep their value.
- R8: `grp_sel` holds 1 bit per group: bit 0 selects the timer for group 0 (bits 7:0) and bit 1 selects the timer for group 1 (bits 15:8), with value 0 meaning timer 0 and 1 meaning timer 1.
- R9: `pin_oe` equals `dir_mask & nde_mask`, and `pin_out` shows the live bit only where `pin_oe` is 1 and is 0 elsewhere.
- R10: `out_wr` loads the live register directly. If a trigger fires in the same cycle, the triggered, enabled bits take the buffer value instead.
- R11: If `nxt_wr` coincides with a trigger, the value already in the buffer is transferred, and the new word is used from the next trigger onward.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| out_wr | input | 1 | Load strobe for the live output register |
| out_wdata | input | 16 | Value for the live output register |
| nxt_wr | input | 1 | Load strobe for the next-data buffer (software or refill engine) |
| nxt_wdata | input | 16 | Value for the next-data buffer |
| dir_mask | input | 16 | Per-bit direction (1 = output) |
| nde_mask | input | 16 | Per-bit next-data enable |
| grp_sel | input | 2 | Trigger timer choice, one bit per group |
| tmr_run | input | 2 | Run bit per timer |
| per_wr | input | 2 | Period write strobe per timer |
| per_wdata | input | 16 | Period value, shared by both timers |
| refill_done | input | 2 | Refill-complete strobe per timer, clears its flag |
| flag_wr0 | input | 2 | Software write-zero strobe per timer, clears its flag |
| pin_out | output | 16 | Driven pattern, zero on undriven bits |
| pin_oe | output | 16 | Per-bit output enable |
| match_flag | output | 2 | Sticky compare-match flag per timer, used as the refill request |

## Verification
Every result appears one clock edge after its cause. A match condition exists during the cycle in which the registered count equals the period. The flag and the live register update together at the next edge, and a change to the enable masks shows on `pin_oe` and `pin_out` in the same cycle. The bench changes inputs only at falling edges and advances a behavioural reference model at each rising edge from those settled inputs. It compares every output with the model at the next falling edge, once all registers on the path have taken their new values. It adds a directed count of the edges from run to first flag.

// File: rtl/ppo_pkg.sv
package ppo_pkg;

    typedef enum logic {
        CNT_HALT = 1'b0,
        CNT_RUN  = 1'b1
    } cnt_st_e;

    typedef enum logic {
        FLG_IDLE = 1'b0,
        FLG_PEND = 1'b1
    } flg_st_e;

endpackage

// File: rtl/ppo_timer.sv
module ppo_timer
    import ppo_pkg::*;
#(
    parameter int CNT_W = 16
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             run,
    input  logic             per_wr,
    input  logic [CNT_W-1:0] per_wdata,
    input  logic             clr_req,
    output logic             match,
    output logic             flag
);

    cnt_st_e          cst_q, cst_d;
    flg_st_e          fst_q, fst_d;
    logic [CNT_W-1:0] cnt_q;
    logic [CNT_W-1:0] per_q;

    // next-state logic for both machines
    always_comb begin
        unique case (cst_q)
            CNT_HALT: cst_d = run ? CNT_RUN : CNT_HALT;
            CNT_RUN:  cst_d = run ? CNT_RUN : CNT_HALT;
            default:  cst_d = CNT_HALT;
        endcase
        unique case (fst_q)
            FLG_IDLE: fst_d = match ? FLG_PEND : FLG_IDLE;
            FLG_PEND: fst_d = (match || !clr_req) ? FLG_PEND : FLG_IDLE;
            default:  fst_d = FLG_IDLE;
        endcase
    end

    // state registers
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cst_q <= CNT_HALT;
            fst_q <= FLG_IDLE;
        end else begin
            cst_q <= cst_d;
            fst_q <= fst_d;
        end
    end

    // outputs of the machines
    always_comb begin
        match = (cst_q == CNT_RUN) && (cnt_q == per_q);
        flag  = (fst_q == FLG_PEND);
    end

    // count and period registers
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cnt_q <= '0;
            per_q <= '0;
        end else begin
            if (cst_q == CNT_RUN)
                cnt_q <= match ? '0 : cnt_q + 1'b1;
            if (per_wr)
                per_q <= per_wdata;
        end
    end

    // R2: a halted counter keeps its value
    a_r2_hold_when_halted: assert property (@(posedge clk) disable iff (!rst_n)
        (cst_q == CNT_HALT) |=> $stable(cnt_q));

    // R3: a match restarts the count from zero
    a_r3_match_restarts: assert property (@(posedge clk) disable iff (!rst_n)
        match |=> (cnt_q == '0));

    // R5: a match leaves the flag set
    a_r5_flag_after_match: assert property (@(posedge clk) disable iff (!rst_n)
        match |=> flag);

    // R6: a clear without a concurrent match drops the flag
    a_r6_clear_drops_flag: assert property (@(posedge clk) disable iff (!rst_n)
        (clr_req && !match) |=> !flag);

endmodule

// File: rtl/ppo_outreg.sv
module ppo_outreg #(
    parameter int GRP_W   = 8,
    parameter int NUM_GRP = 2,
    parameter int NUM_TMR = 2,
    parameter int SEL_W   = 1
) (
    input  logic                       clk,
    input  logic                       rst_n,
    input  logic                       out_wr,
    input  logic [NUM_GRP*GRP_W-1:0]   out_wdata,
    input  logic                       nxt_wr,
    input  logic [NUM_GRP*GRP_W-1:0]   nxt_wdata,
    input  logic [NUM_GRP*GRP_W-1:0]   nde,
    input  logic [NUM_GRP*SEL_W-1:0]   grp_sel,
    input  logic [NUM_TMR-1:0]         match,
    output logic [NUM_GRP*GRP_W-1:0]   out_q
);

    localparam int DW = NUM_GRP * GRP_W;

    logic [DW-1:0]      nxt_q;
    logic [DW-1:0]      upd_mask;
    logic [DW-1:0]      out_d;
    logic [NUM_GRP-1:0] trig;

    // per-group trigger from the selected timer
    always_comb begin
        for (int g = 0; g < NUM_GRP; g++) begin
            trig[g] = 1'b0;
            for (int t = 0; t < NUM_TMR; t++) begin
                if (grp_sel[g*SEL_W +: SEL_W] == SEL_W'(t))
                    trig[g] = trig[g] | match[t];
            end
        end
    end

    for (genvar g = 0; g < NUM_GRP; g++) begin : g_grp
        assign upd_mask[g*GRP_W +: GRP_W] = {GRP_W{trig[g]}} & nde[g*GRP_W +: GRP_W];
    end

    always_comb begin
        out_d = ((out_wr ? out_wdata : out_q) & ~upd_mask) | (nxt_q & upd_mask);
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            out_q <= '0;
            nxt_q <= '0;
        end else begin
            out_q <= out_d;
            if (nxt_wr)
                nxt_q <= nxt_wdata;
        end
    end

    // R7: without a software write, bits with their enable clear never change
    a_r7_disabled_bits_keep: assert property (@(posedge clk) disable iff (!rst_n)
        !out_wr |=> (((out_q ^ $past(out_q)) & ~$past(nde)) == '0));

    // R7: with no trigger and no software write the live word is stable
    a_r7_quiet_without_trigger: assert property (@(posedge clk) disable iff (!rst_n)
        (!out_wr && (trig == '0)) |=> $stable(out_q));

endmodule

// File: rtl/pulse_pattern_out.sv
module pulse_pattern_out #(
    parameter int GRP_W   = 8,
    parameter int NUM_GRP = 2,
    parameter int NUM_TMR = 2,
    parameter int CNT_W   = 16
) (
    input  logic                             clk,
    input  logic                             rst_n,
    input  logic                             out_wr,
    input  logic [NUM_GRP*GRP_W-1:0]         out_wdata,
    input  logic                             nxt_wr,
    input  logic [NUM_GRP*GRP_W-1:0]         nxt_wdata,
    input  logic [NUM_GRP*GRP_W-1:0]         dir_mask,
    input  logic [NUM_GRP*GRP_W-1:0]         nde_mask,
    input  logic [NUM_GRP*((NUM_TMR > 1) ? $clog2(NUM_TMR) : 1)-1:0] grp_sel,
    input  logic [NUM_TMR-1:0]               tmr_run,
    input  logic [NUM_TMR-1:0]               per_wr,
    input  logic [CNT_W-1:0]                 per_wdata,
    input  logic [NUM_TMR-1:0]               refill_done,
    input  logic [NUM_TMR-1:0]               flag_wr0,
    output logic [NUM_GRP*GRP_W-1:0]         pin_out,
    output logic [NUM_GRP*GRP_W-1:0]         pin_oe,
    output logic [NUM_TMR-1:0]               match_flag
);

    localparam int DW    = NUM_GRP * GRP_W;
    localparam int SEL_W = (NUM_TMR > 1) ? $clog2(NUM_TMR) : 1;

    logic [NUM_TMR-1:0] match;
    logic [DW-1:0]      out_q;

    for (genvar t = 0; t < NUM_TMR; t++) begin : g_tmr
        ppo_timer #(.CNT_W(CNT_W)) i_tmr (
            .clk       (clk),
            .rst_n     (rst_n),
            .run       (tmr_run[t]),
            .per_wr    (per_wr[t]),
            .per_wdata (per_wdata),
            .clr_req   (refill_done[t] | flag_wr0[t]),
            .match     (match[t]),
            .flag      (match_flag[t])
        );
    end

    ppo_outreg #(
        .GRP_W   (GRP_W),
        .NUM_GRP (NUM_GRP),
        .NUM_TMR (NUM_TMR),
        .SEL_W   (SEL_W)
    ) i_outreg (
        .clk       (clk),
        .rst_n     (rst_n),
        .out_wr    (out_wr),
        .out_wdata (out_wdata),
        .nxt_wr    (nxt_wr),
        .nxt_wdata (nxt_wdata),
        .nde       (nde_mask),
        .grp_sel   (grp_sel),
        .match     (match),
        .out_q     (out_q)
    );

    always_comb begin
        pin_oe  = dir_mask & nde_mask;
        pin_out = out_q & pin_oe;
    end

    // R9: a bit shows a one only where direction and enable are both set
    a_r9_no_stray_drive: assert property (@(posedge clk) disable iff (!rst_n)
        ((pin_out & ~(dir_mask & nde_mask)) == '0));

    // R8: a group whose selected timer has no match keeps its live bits
    a_r8_group0_follows_select: assert property (@(posedge clk) disable iff (!rst_n)
        (!out_wr && !match[grp_sel[0 +: SEL_W]]) |=> $stable(out_q[GRP_W-1:0]));

endmodule

// File: tb/test_pulse_pattern_out.sv
module test_pulse_pattern_out;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        out_wr = 1'b0;
    logic [15:0] out_wdata = '0;
    logic        nxt_wr = 1'b0;
    logic [15:0] nxt_wdata = '0;
    logic [15:0] dir_mask = '0;
    logic [15:0] nde_mask = '0;
    logic [1:0]  grp_sel = '0;
    logic [1:0]  tmr_run = '0;
    logic [1:0]  per_wr = '0;
    logic [15:0] per_wdata = '0;
    logic [1:0]  refill_done = '0;
    logic [1:0]  flag_wr0 = '0;
    logic [15:0] pin_out;
    logic [15:0] pin_oe;
    logic [1:0]  match_flag;

    always #5 clk = ~clk;

    pulse_pattern_out i_pulse_pattern_out (
        .clk(clk), .rst_n(rst_n), .out_wr(out_wr), .out_wdata(out_wdata),
        .nxt_wr(nxt_wr), .nxt_wdata(nxt_wdata), .dir_mask(dir_mask),
        .nde_mask(nde_mask), .grp_sel(grp_sel), .tmr_run(tmr_run),
        .per_wr(per_wr), .per_wdata(per_wdata), .refill_done(refill_done),
        .flag_wr0(flag_wr0), .pin_out(pin_out), .pin_oe(pin_oe),
        .match_flag(match_flag)
    );

    int    checks = 0;
    int    errors = 0;
    int    wd     = 0;
    string tag    = "R1";

    // behavioural reference
    int       m_cnt  [2];
    int       m_per  [2];
    bit       m_run  [2];
    bit       m_flag [2];
    bit [15:0] m_out;
    bit [15:0] m_nxt;

    always @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            for (int i = 0; i < 2; i++) begin
                m_cnt[i] = 0; m_per[i] = 0; m_run[i] = 0; m_flag[i] = 0;
            end
            m_out = '0;
            m_nxt = '0;
        end else begin
            bit        hit [2];
            bit [15:0] nv;
            for (int i = 0; i < 2; i++)
                hit[i] = m_run[i] && (m_cnt[i] == m_per[i]);
            nv = out_wr ? out_wdata : m_out;
            for (int g = 0; g < 2; g++)
                if (hit[grp_sel[g]])
                    for (int b = g*8; b < g*8+8; b++)
                        if (nde_mask[b]) nv[b] = m_nxt[b];
            m_out = nv;
            if (nxt_wr) m_nxt = nxt_wdata;
            for (int i = 0; i < 2; i++) begin
                if (m_run[i]) m_cnt[i] = hit[i] ? 0 : (m_cnt[i] + 1) % 65536;
                if (per_wr[i]) m_per[i] = per_wdata;
                if (hit[i]) m_flag[i] = 1;
                else if (refill_done[i] || flag_wr0[i]) m_flag[i] = 0;
                m_run[i] = tmr_run[i];
            end
        end
    end

    task automatic chk(input string what, input logic [15:0] act, input logic [15:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s %s actual=%h expected=%h", tag, what, act, exp);
        end
    endtask

    task automatic tick;
        @(negedge clk);
        chk("pin_oe", pin_oe, dir_mask & nde_mask);
        chk("pin_out", pin_out, m_out & dir_mask & nde_mask);
        chk("match_flag", {14'b0, match_flag}, {14'b0, m_flag[1], m_flag[0]});
        out_wr = 0; nxt_wr = 0; per_wr = '0; refill_done = '0; flag_wr0 = '0;
    endtask

    task automatic ticks(input int n);
        for (int i = 0; i < n; i++) tick();
    endtask

    always @(posedge clk) begin
        wd++;
        if (wd > 100000) begin
            errors++;
            $display("FAIL watchdog expired");
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

    initial begin
        int n;
        repeat (3) @(negedge clk);
        rst_n = 1;
        tag = "R1";
        chk("reset pin_out", pin_out, 16'h0000);
        chk("reset flags", {14'b0, match_flag}, 16'h0000);
        dir_mask = 16'hFFFF; nde_mask = 16'hFFFF;
        tick();
        chk("reset live word", pin_out, 16'h0000);

        tag = "R10";
        out_wr = 1; out_wdata = 16'hA55A;
        tick();
        chk("direct load", pin_out, 16'hA55A);

        tag = "R9";
        dir_mask = 16'h00FF; nde_mask = 16'h0F0F;
        tick();
        chk("masked drive", pin_out, 16'hA55A & 16'h000F);
        dir_mask = 16'hFFFF; nde_mask = 16'hFFFF;

        tag = "R2";
        per_wr = 2'b01; per_wdata = 16'd3; nxt_wr = 1; nxt_wdata = 16'h1234;
        ticks(10);
        chk("no flag while halted", {14'b0, match_flag}, 16'h0000);

        tag = "R3";
        tmr_run = 2'b01;
        n = 0;
        while (match_flag[0] !== 1'b1 && n < 20) begin tick(); n++; end
        chk("edges to first flag", 16'(n), 16'd5);
        chk("triggered word", pin_out, 16'h1234);

        tag = "R5";
        ticks(9);
        tag = "R6";
        refill_done = 2'b01; tick();
        chk("flag cleared by refill", {15'b0, match_flag[0]}, 16'h0000);
        ticks(2);
        flag_wr0 = 2'b01; tick();
        ticks(6);
        for (int k = 0; k < 8; k++) begin flag_wr0 = 2'b01; tick(); end

        tag = "R4";
        per_wr = 2'b01; per_wdata = 16'd6; ticks(20);
        per_wr = 2'b01; per_wdata = 16'd1; refill_done = 2'b01; ticks(12);

        tag = "R2";
        tmr_run = 2'b00; ticks(8);
        tmr_run = 2'b01;

        tag = "R8";
        per_wr = 2'b10; per_wdata = 16'd4; tmr_run = 2'b11; grp_sel = 2'b10;
        nxt_wr = 1; nxt_wdata = 16'hC3C3; ticks(30);

        tag = "R7";
        nde_mask = 16'h3C5A; nxt_wr = 1; nxt_wdata = 16'hFFFF; ticks(20);
        nxt_wr = 1; nxt_wdata = 16'h0000; ticks(20);

        tag = "R11";
        for (int k = 0; k < 400; k++) begin
            nxt_wr      = ($urandom_range(0, 2) == 0);
            nxt_wdata   = 16'($urandom);
            out_wr      = ($urandom_range(0, 9) == 0);
            out_wdata   = 16'($urandom);
            nde_mask    = 16'($urandom);
            dir_mask    = 16'($urandom);
            grp_sel     = 2'($urandom);
            tmr_run     = ($urandom_range(0, 7) == 0) ? 2'($urandom) : 2'b11;
            per_wr      = ($urandom_range(0, 4) == 0) ? 2'($urandom) : 2'b00;
            per_wdata   = 16'($urandom_range(0, 5));
            refill_done = 2'($urandom);
            flag_wr0    = ($urandom_range(0, 3) == 0) ? 2'($urandom) : 2'b00;
            @(negedge clk);
            chk("pin_oe", pin_oe, dir_mask & nde_mask);
            chk("pin_out", pin_out, m_out & dir_mask & nde_mask);
            chk("match_flag", {14'b0, match_flag}, {14'b0, m_flag[1], m_flag[0]});
        end

        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

endmodule